// File: doc/BRIEF.md
# Non-Destructive Address-Line Walker

This engine tests one memory from the outside while the memory holds live data. It runs in two phases, and it saves every word it overwrites and writes that word back afterwards. In the first phase it checks the base cell: it writes the inverse of the stored word, reads the cell back, then puts the original word back and reads the cell again. In the second phase it walks a single set bit upward across the address. For each address bit it saves the word at the probe location and writes the inverse of the base word there. It then reads the base location again. If the base word has changed, the two addresses are not independent: the address line is stuck or shorted to another line.

Software starts a run with a start pulse and a base address. For the whole run the engine owns the memory port. While `busy` is high, other masters must stay off the bus. The `hold` input stands in for the masking that software normally does. While `hold` is high, the engine starts no new read and accepts no start. At the end of a run, `done` pulses for one cycle. A pass or fail result stays on the outputs until the next run begins, together with a cell-fault flag and the index of the faulty address line.

Top module: `aw_walker`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `fail` and `mem_en` are all low.
- R2: When `start` is high, `hold` is low and the engine is idle, the engine begins a run on the next cycle. `busy` stays high up to and including the `done` cycle. A `start` pulse that arrives during a run is ignored.
- R3: The cell test accesses the base address in this order: read; write the inverse of the value read; read and compare against that inverse; write the saved value back; read and compare against the saved value. Any mismatch ends the run with `fail`=1, `fail_cell`=1 and `fail_bit`=0.
- R4: For each address bit b, from LO_BIT up to AW-1 in ascending order, the probe address is the base address with bit b inverted. For each probe the engine reads and saves the probe word, writes the inverse of the saved base word to the probe, rereads the base, and writes the saved probe word back.
- R5: If the reread base word differs from the saved base word, the run ends with `fail`=1, `fail_cell`=0 and `fail_bit`=b. No higher bit is probed.
- R6: After a run that passes, or that fails on an address line, every memory location holds the value it had before `start`. On an address failure the base word is written back after the probe is restored.
- R7: If no mismatch occurs, `pass`=1 and `fail`=0 at `done`. `pass` and `fail` never both read 1, and both stay unchanged until the next accepted start clears them.
- R8: While `hold` is high, no read is issued and no start is accepted. Once `hold` drops, the run carries on to the same result.
- R9: `done` is a single-cycle pulse and `busy` drops in the cycle after it. A passing run without hold keeps `busy` high for 7+4·NB cycles and issues 3+2·NB reads and 2+2·NB writes, where NB = AW−LO_BIT.
- R10: Address bits below LO_BIT are never probed, so an alias on such a bit does not cause a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (sampled when idle) |
| hold | input | 1 | Hold-off request: blocks new reads and starts |
| base_addr | input | AW | Base address, captured at start |
| busy | output | 1 | Engine owns the memory port |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run found no fault |
| fail | output | 1 | Last run found a fault |
| fail_cell | output | 1 | Fault was in the base cell test |
| fail_bit | output | $clog2(AW) | Index of the faulty address line |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after a read |

## Verification
The checker enforces, on every cycle, the rules that tie the port together. It checks that no read is issued under hold and no access occurs outside a run. It checks that `done` lasts exactly one cycle and that `busy` falls right after it. It checks that an accepted start clears the result, that the result is stable while idle, that pass and fail never both read 1, and that a reported line lies at or above LO_BIT.

Only the bench scenarios can show the effect of the walk on memory. They inject aliasing on a chosen address line and a stuck data bit in the base cell. They then confirm the reported line, the exact access counts, and that memory is unchanged after a run that passes or fails on an address line.

// File: rtl/aw_pkg.sv
package aw_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_C_RD0,
        S_C_SAVE,
        S_C_RD1,
        S_C_CHK1,
        S_C_RD2,
        S_C_CHK2,
        S_A_RDP,
        S_A_WRP,
        S_A_RDB,
        S_A_CHK,
        S_A_FIX,
        S_DONE
    } aw_state_e;

    typedef enum logic [2:0] {
        WD_NONE,
        WD_INV_RD,
        WD_SAVE,
        WD_INV_SAVE,
        WD_PSAVE
    } aw_wsel_e;

    typedef struct packed {
        logic     en;
        logic     we;
        logic     at_probe;
        aw_wsel_e wsel;
    } aw_cmd_t;

    // Memory command issued in each state.
    function automatic aw_cmd_t cmd_of(aw_state_e s);
        aw_cmd_t c;
        c = '{en: 1'b0, we: 1'b0, at_probe: 1'b0, wsel: WD_NONE};
        case (s)
            S_C_RD0, S_C_RD1, S_C_RD2, S_A_RDB: c.en = 1'b1;
            S_A_RDP:  c = '{en: 1'b1, we: 1'b0, at_probe: 1'b1, wsel: WD_NONE};
            S_C_SAVE: c = '{en: 1'b1, we: 1'b1, at_probe: 1'b0, wsel: WD_INV_RD};
            S_C_CHK1: c = '{en: 1'b1, we: 1'b1, at_probe: 1'b0, wsel: WD_SAVE};
            S_A_WRP:  c = '{en: 1'b1, we: 1'b1, at_probe: 1'b1, wsel: WD_INV_SAVE};
            S_A_CHK:  c = '{en: 1'b1, we: 1'b1, at_probe: 1'b1, wsel: WD_PSAVE};
            S_A_FIX:  c = '{en: 1'b1, we: 1'b1, at_probe: 1'b0, wsel: WD_SAVE};
            default:  ;
        endcase
        return c;
    endfunction

    // States that issue a read and therefore wait while hold is high.
    function automatic logic is_read_issue(aw_state_e s);
        return (s == S_C_RD0) || (s == S_C_RD1) || (s == S_C_RD2) ||
               (s == S_A_RDP) || (s == S_A_RDB);
    endfunction

endpackage

// File: rtl/aw_probe_gen.sv
module aw_probe_gen #(
    parameter int AW     = 12,
    parameter int LO_BIT = 0,
    localparam int BW    = (AW > 1) ? $clog2(AW) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] base_in,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] probe_addr,
    output logic [BW-1:0] bit_idx,
    output logic          last
);
    localparam logic [BW-1:0] FIRST = BW'(LO_BIT);
    localparam logic [BW-1:0] FINAL = BW'(AW - 1);
    localparam logic [AW-1:0] ONE   = AW'(1);

    logic [BW-1:0] bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            bit_q  <= FIRST;
        end else if (load) begin
            base_q <= base_in;
            bit_q  <= FIRST;
        end else if (step) begin
            bit_q  <= bit_q + 1'b1;
        end
    end

    assign probe_addr = base_q ^ (ONE << bit_q);
    assign bit_idx    = bit_q;
    assign last       = (bit_q == FINAL);
endmodule

// File: rtl/aw_seq.sv
module aw_seq
    import aw_pkg::*;
#(
    parameter int DW     = 16,
    parameter int AW     = 12,
    localparam int BW    = (AW > 1) ? $clog2(AW) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          hold,
    input  logic [DW-1:0] rdata,
    input  logic          last,
    input  logic [BW-1:0] bit_idx,
    output logic          load,
    output logic          step,
    output logic          mem_en,
    output logic          mem_we,
    output logic          at_probe,
    output logic [DW-1:0] wdata,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic          fail_cell,
    output logic [BW-1:0] fail_bit
);
    aw_state_e     state_q, state_d;
    aw_cmd_t       cmd;
    logic [DW-1:0] save_q, psave_q;
    logic          set_pass, set_cell, set_addr;

    assign cmd = cmd_of(state_q);

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        step     = 1'b0;
        set_pass = 1'b0;
        set_cell = 1'b0;
        set_addr = 1'b0;
        case (state_q)
            S_IDLE:   if (start && !hold) begin
                          state_d = S_C_RD0;
                          load    = 1'b1;
                      end
            S_C_RD0:  if (!hold) state_d = S_C_SAVE;
            S_C_SAVE: state_d = S_C_RD1;
            S_C_RD1:  if (!hold) state_d = S_C_CHK1;
            S_C_CHK1: if (rdata != ~save_q) begin
                          state_d  = S_DONE;
                          set_cell = 1'b1;
                      end else state_d = S_C_RD2;
            S_C_RD2:  if (!hold) state_d = S_C_CHK2;
            S_C_CHK2: if (rdata != save_q) begin
                          state_d  = S_DONE;
                          set_cell = 1'b1;
                      end else state_d = S_A_RDP;
            S_A_RDP:  if (!hold) state_d = S_A_WRP;
            S_A_WRP:  state_d = S_A_RDB;
            S_A_RDB:  if (!hold) state_d = S_A_CHK;
            S_A_CHK:  if (rdata != save_q) state_d = S_A_FIX;
                      else if (last) begin
                          state_d  = S_DONE;
                          set_pass = 1'b1;
                      end else begin
                          state_d = S_A_RDP;
                          step    = 1'b1;
                      end
            S_A_FIX:  begin
                          state_d  = S_DONE;
                          set_addr = 1'b1;
                      end
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            save_q    <= '0;
            psave_q   <= '0;
            pass      <= 1'b0;
            fail      <= 1'b0;
            fail_cell <= 1'b0;
            fail_bit  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_C_SAVE) save_q  <= rdata;
            if (state_q == S_A_WRP)  psave_q <= rdata;
            if (load) begin
                pass      <= 1'b0;
                fail      <= 1'b0;
                fail_cell <= 1'b0;
                fail_bit  <= '0;
            end
            if (set_pass) pass <= 1'b1;
            if (set_cell) begin
                fail      <= 1'b1;
                fail_cell <= 1'b1;
            end
            if (set_addr) begin
                fail     <= 1'b1;
                fail_bit <= bit_idx;
            end
        end
    end

    always_comb begin
        case (cmd.wsel)
            WD_INV_RD:   wdata = ~rdata;
            WD_SAVE:     wdata = save_q;
            WD_INV_SAVE: wdata = ~save_q;
            WD_PSAVE:    wdata = psave_q;
            default:     wdata = '0;
        endcase
    end

    assign mem_en   = cmd.en && !(is_read_issue(state_q) && hold);
    assign mem_we   = cmd.we;
    assign at_probe = cmd.at_probe;
    assign busy     = (state_q != S_IDLE);
    assign done     = (state_q == S_DONE);
endmodule

// File: rtl/aw_walker.sv
module aw_walker #(
    parameter int AW     = 12,
    parameter int DW     = 16,
    parameter int LO_BIT = 0,
    localparam int BW    = (AW > 1) ? $clog2(AW) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          hold,
    input  logic [AW-1:0] base_addr,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic          fail_cell,
    output logic [BW-1:0] fail_bit,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    logic          load, step, last, at_probe;
    logic [AW-1:0] base_q, probe_addr;
    logic [BW-1:0] bit_idx;

    aw_probe_gen #(.AW(AW), .LO_BIT(LO_BIT)) u_gen (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .step       (step),
        .base_in    (base_addr),
        .base_q     (base_q),
        .probe_addr (probe_addr),
        .bit_idx    (bit_idx),
        .last       (last)
    );

    aw_seq #(.DW(DW), .AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .hold      (hold),
        .rdata     (mem_rdata),
        .last      (last),
        .bit_idx   (bit_idx),
        .load      (load),
        .step      (step),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .at_probe  (at_probe),
        .wdata     (mem_wdata),
        .busy      (busy),
        .done      (done),
        .pass      (pass),
        .fail      (fail),
        .fail_cell (fail_cell),
        .fail_bit  (fail_bit)
    );

    assign mem_addr = at_probe ? probe_addr : base_q;
endmodule

// File: rtl/aw_walker_chk.sv
module aw_walker_chk #(
    parameter int AW     = 12,
    parameter int LO_BIT = 0,
    localparam int BW    = (AW > 1) ? $clog2(AW) : 1
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          hold,
    input logic          busy,
    input logic          done,
    input logic          pass,
    input logic          fail,
    input logic          fail_cell,
    input logic [BW-1:0] fail_bit,
    input logic          mem_en,
    input logic          mem_we
);
    p_no_read_on_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_we) |-> !hold);

    p_access_in_run_r2: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> busy);

    p_start_taken_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !hold) |=> (busy && !pass && !fail));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    p_result_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail));

    p_result_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(start && !hold)) |=> ($stable(pass) && $stable(fail)));

    p_line_in_range_r10: assert property (@(posedge clk) disable iff (rst)
        (done && fail && !fail_cell) |-> (int'(fail_bit) >= LO_BIT));
endmodule

bind aw_walker aw_walker_chk #(.AW(AW), .LO_BIT(LO_BIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .hold      (hold),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .fail      (fail),
    .fail_cell (fail_cell),
    .fail_bit  (fail_bit),
    .mem_en    (mem_en),
    .mem_we    (mem_we)
);

// File: tb/sim_aw_walker.sv
module sim_aw_walker;
    localparam int AW    = 8;
    localparam int DW    = 16;
    localparam int LO    = 1;
    localparam int NB    = AW - LO;
    localparam int DEPTH = 1 << AW;
    localparam int BW    = $clog2(AW);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          hold = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          busy, done, pass, fail, fail_cell;
    logic [BW-1:0] fail_bit;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    always #4 clk = ~clk;   // 125 MHz

    aw_walker #(.AW(AW), .DW(DW), .LO_BIT(LO)) u0 (
        .clk(clk), .rst(rst), .start(start), .hold(hold), .base_addr(base_addr),
        .busy(busy), .done(done), .pass(pass), .fail(fail), .fail_cell(fail_cell),
        .fail_bit(fail_bit), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model with injectable faults
    logic [DW-1:0] mem  [DEPTH];
    logic [DW-1:0] orig [DEPTH];
    int            alias_bit = -1;
    logic          stuck_en = 1'b0;
    logic [AW-1:0] stuck_addr = '0;
    logic [AW-1:0] phys;

    always_comb begin
        phys = mem_addr;
        if (alias_bit >= 0) phys[alias_bit] = 1'b0;
    end

    always @(posedge clk) begin
        if (mem_en && mem_we) mem[phys] <= mem_wdata;
        if (mem_en && !mem_we)
            mem_rdata <= mem[phys] | ((stuck_en && phys == stuck_addr) ? DW'(1) : DW'(0));
    end

    int checks = 0, errors = 0;
    int busy_cnt, rd_cnt, wr_cnt, hold_rd, done_cnt = 0;
    int exp_q[$];

    // Monitor: samples 2 ns after the rising edge
    always @(posedge clk) begin
        #2;
        if (busy) busy_cnt++;
        if (mem_en && !mem_we) rd_cnt++;
        if (mem_en && mem_we) wr_cnt++;
        if (hold && mem_en && !mem_we) hold_rd++;
        if (done) begin
            int e, got;
            done_cnt++;
            checks++;
            got = {fail, pass, fail_cell, 1'b0} * 16 + int'(fail_bit);
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2/R9: unexpected done, got %0h expected none", got);
            end else begin
                e = exp_q.pop_front();
                if (got != e) begin
                    errors++;
                    $display("FAIL R3/R5/R7: result got %0h expected %0h", got, e);
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected code: {fail, pass, cell, 0} * 16 + bit
    function automatic int code(input bit f, input bit c, input int b);
        return {f, !f, c, 1'b0} * 16 + b;
    endfunction

    task automatic run(input logic [AW-1:0] base, input bit f, input bit c, input int b,
                       input bit counts, input bit chk_mem, input string req);
        int d0, mism;
        for (int i = 0; i < DEPTH; i++) orig[i] = mem[i];
        exp_q.push_back(code(f, c, b));
        busy_cnt = 0; rd_cnt = 0; wr_cnt = 0; hold_rd = 0;
        d0 = done_cnt;
        @(negedge clk); base_addr = base; start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int t = 0; t < 2000 && done_cnt == d0; t++) @(negedge clk);
        check(done_cnt == d0 + 1, {req, " done seen"}, done_cnt - d0, 1);
        @(negedge clk);
        if (counts) begin
            check(busy_cnt == 7 + 4 * NB, "R9 busy cycles", busy_cnt, 7 + 4 * NB);
            check(rd_cnt == 3 + 2 * NB, "R9/R4 reads", rd_cnt, 3 + 2 * NB);
            check(wr_cnt == 2 + 2 * NB, "R9/R4 writes", wr_cnt, 2 + 2 * NB);
        end
        if (chk_mem) begin
            mism = 0;
            for (int i = 0; i < DEPTH; i++) if (mem[i] !== orig[i]) mism++;
            check(mism == 0, "R6 memory restored", mism, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = DW'($urandom);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check({busy, done, pass, fail, mem_en} == 5'b0, "R1 reset outputs",
              int'({busy, done, pass, fail, mem_en}), 0);

        // R7 R4 R9 R6: clean runs at two bases
        run(8'h00, 0, 0, 0, 1, 1, "R7");
        run(8'h5A, 0, 0, 0, 1, 1, "R7");
        repeat (5) @(negedge clk);
        check(pass && !fail, "R7 result held", int'({pass, fail}), 2);

        // R5: address line 3 aliased (stuck low)
        alias_bit = 3;
        run(8'h00, 1, 0, 3, 0, 1, "R5");
        alias_bit = 6;
        run(8'h81, 1, 0, 6, 0, 1, "R5");
        // R10: alias on bit 0 is below LO_BIT, so the run passes
        alias_bit = 0;
        run(8'h10, 0, 0, 0, 1, 1, "R10");
        alias_bit = -1;

        // R3: stuck data bit in the base cell
        stuck_en = 1'b1; stuck_addr = 8'h22;
        run(8'h22, 1, 1, 0, 0, 0, "R3");
        stuck_en = 1'b0;

        // R2: second start during a run is ignored
        fork
            run(8'h33, 0, 0, 0, 1, 1, "R2");
            begin
                repeat (6) @(negedge clk);
                base_addr = 8'h44; start = 1'b1;
                @(negedge clk); start = 1'b0;
            end
        join
        repeat (60) @(negedge clk);
        check(!busy && exp_q.size() == 0, "R2 no second run", int'(busy), 0);

        // R8: start blocked while hold is high
        hold = 1'b1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        check(!busy, "R8 start held off", int'(busy), 0);
        hold = 1'b0;

        // R8: hold in the middle of a run
        fork
            run(8'h0F, 0, 0, 0, 0, 1, "R8");
            begin
                repeat (9) @(negedge clk);
                hold = 1'b1;
                repeat (10) @(negedge clk);
                hold = 1'b0;
            end
        join
        check(hold_rd == 0, "R8 no read under hold", hold_rd, 0);
        check(busy_cnt > 7 + 4 * NB, "R8 run stalled", busy_cnt, 7 + 4 * NB + 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule